// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing for a parallel RGB display port. A programmable integer divider turns the core clock into a one-cycle pixel enable. On each enable a horizontal pixel counter advances through four phases: sync, back porch, active and front porch. At the end of every line a vertical line counter advances through the same four phases. HSYNC, VSYNC and data-enable are decoded from the two counters. Every length field holds the real count minus one.

The block also raises a frame interrupt. Software chooses which vertical phase start fires it. A sticky pending flag is set when that line begins and stays set until a clear pulse arrives. The interrupt output is this flag gated by a global enable. A line-compare output is high while the current line equals a programmed threshold. The usual threshold is the last active line.

Register values arrive as plain inputs and must be held steady while video is enabled. Dropping the video enable returns both counters to zero and forces every raster output low.

Top module: `raster_timing_gen`

## Requirements
- R1: With divider field D, `pix_ce` is high for exactly one core cycle in every D+1. After `video_en` rises, the first pulse comes in cycle D, counting the first enabled cycle as 0. D=0xFF gives a ratio of 256.
- R2: `h_cnt` starts at 0, advances by one on each `pix_ce`, and wraps to 0 after reaching HT-1. HT is the sum of the four horizontal fields plus 4.
- R3: `hsync` is high, active high, exactly while `h_cnt` is at most the sync field. The horizontal phase order is sync, back porch, active, front porch.
- R4: `v_cnt` advances by one on the `pix_ce` that wraps `h_cnt`, and wraps after VT-1, where VT is the sum of the four vertical fields plus 4. `vsync` is high exactly while `v_cnt` is at most the vertical sync field. The vertical phases follow the same order as the horizontal ones.
- R5: `de` is high only when both counters are inside their active phases. For the horizontal counter that is from (sync+back+2) up to but not including (sync+back+active+3); the vertical window is defined the same way.
- R6: While `video_en` is low, both counters hold at 0 and `pix_ce`, `hsync`, `vsync`, `de` and `line_match` are low.
- R7: `irq_pend` is set when `v_cnt` steps into the line selected by `irq_sel`, provided `irq_frame_en` is high. The encoding is 0 = start of sync (line 0, reached only by wrapping), 1 = start of back porch, 2 = start of active, 3 = start of front porch. With `irq_frame_en` low the flag is never set.
- R8: `irq` equals `irq_pend` AND `irq_glob_en`.
- R9: `irq_pend` is sticky. A one on `irq_clr` clears it at the next edge. If a set and a clear fall in the same cycle, the set wins.
- R10: `line_match` is high while video is enabled and `v_cnt` equals `line_thresh`.
- R11: During reset, and at its release, the counters, `irq_pend` and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| video_en | input | 1 | Runs the raster; low holds it idle |
| div_m1 | input | 8 | Pixel divide ratio minus one |
| h_sync_m1 | input | 12 | Horizontal sync width minus one |
| h_back_m1 | input | 12 | Horizontal back porch minus one |
| h_act_m1 | input | 12 | Active width minus one |
| h_front_m1 | input | 12 | Horizontal front porch minus one |
| v_sync_m1 | input | 11 | Vertical sync lines minus one |
| v_back_m1 | input | 11 | Vertical back porch minus one |
| v_act_m1 | input | 11 | Active height minus one |
| v_front_m1 | input | 11 | Vertical front porch minus one |
| line_thresh | input | 11 | Line number for the compare output |
| irq_glob_en | input | 1 | Global interrupt enable |
| irq_frame_en | input | 1 | Frame interrupt source enable |
| irq_sel | input | 2 | Vertical phase start that fires the frame event |
| irq_clr | input | 1 | Write-one clear of the pending flag |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Data enable |
| h_cnt | output | 12 | Pixel position within the line |
| v_cnt | output | 11 | Line position within the frame |
| line_match | output | 1 | Current line equals the threshold |
| irq_pend | output | 1 | Sticky frame event flag |
| irq | output | 1 | Gated frame interrupt |

## Verification
The frame event that sets the pending flag and a software clear pulse can land in the same core cycle. The bench provokes this by raising `irq_clr` in the cycle just before the vertical wrap, a cycle it computes from the divider and phase lengths. It then expects the flag to remain set. A second clear placed later in the frame must drop the flag on the following sample, and a clear while the flag is already low must leave it low.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

  // Common position width; axis counters are zero-extended into it.
  localparam int PW = 16;
  typedef logic [PW-1:0] pos_t;

  // Frame-event source selection: the start of one vertical phase.
  typedef enum logic [1:0] {
    EVT_SYNC  = 2'd0,
    EVT_BACK  = 2'd1,
    EVT_ACT   = 2'd2,
    EVT_FRONT = 2'd3
  } evt_sel_e;

  // First position of each phase, plus the total span of the axis.
  typedef struct packed {
    pos_t back_at;
    pos_t act_at;
    pos_t front_at;
    pos_t total;
  } bounds_t;

  // Each field is stored as its length minus one.
  function automatic bounds_t phase_bounds(input pos_t sync_m1, input pos_t back_m1,
                                           input pos_t act_m1, input pos_t front_m1);
    bounds_t b;
    b.back_at  = sync_m1 + pos_t'(1);
    b.act_at   = b.back_at + back_m1 + pos_t'(1);
    b.front_at = b.act_at + act_m1 + pos_t'(1);
    b.total    = b.front_at + front_m1 + pos_t'(1);
    return b;
  endfunction

  function automatic pos_t sel_line(input bounds_t b, input evt_sel_e s);
    case (s)
      EVT_BACK:  return b.back_at;
      EVT_ACT:   return b.act_at;
      EVT_FRONT: return b.front_at;
      default:   return '0;
    endcase
  endfunction

endpackage

// File: rtl/rtg_pixdiv.sv
module rtg_pixdiv #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div_m1,
  output logic          tick
);

  logic [DW-1:0] dcnt;

  assign tick = run && (dcnt == div_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dcnt <= '0;
    else if (!run)    dcnt <= '0;
    else if (tick)    dcnt <= '0;
    else              dcnt <= dcnt + 1'b1;
  end

  // R1
  ce_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && $past(tick) && $past(run)) |-> (div_m1 == '0));

endmodule

// File: rtl/rtg_axis.sv
module rtg_axis #(
  parameter int W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               step,
  input  logic [W-1:0]       sync_m1,
  input  logic [W-1:0]       back_m1,
  input  logic [W-1:0]       act_m1,
  input  logic [W-1:0]       front_m1,
  output logic [W-1:0]       cnt,
  output logic [W-1:0]       cnt_nxt,
  output logic               wrap,
  output logic               in_sync,
  output logic               in_act,
  output rtg_pkg::bounds_t   bnd
);
  import rtg_pkg::*;

  pos_t c16;

  assign bnd     = phase_bounds(pos_t'(sync_m1), pos_t'(back_m1), pos_t'(act_m1), pos_t'(front_m1));
  assign c16     = pos_t'(cnt);
  assign wrap    = (c16 == bnd.total - pos_t'(1));
  assign cnt_nxt = wrap ? '0 : cnt + 1'b1;
  assign in_sync = run && (c16 < bnd.back_at);
  assign in_act  = run && (c16 >= bnd.act_at) && (c16 < bnd.front_at);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (step)  cnt <= cnt_nxt;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (c16 < bnd.total));

  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(step)) |-> $stable(cnt));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!run) |-> (cnt == '0));

endmodule

// File: rtl/rtg_frame_irq.sv
module rtg_frame_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic src_en,
  input  logic glob_en,
  input  logic clr,
  output logic pend,
  output logic irq
);

  logic set_now;

  assign set_now = evt && src_en;
  assign irq     = pend && glob_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend <= 1'b0;
    else if (set_now)  pend <= 1'b1;
    else if (clr)      pend <= 1'b0;
  end

  // R7
  pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(evt && src_en));

  // R9
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr && !(evt && src_en)) |-> !pend);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int DW = 8,
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          video_en,
  input  logic [DW-1:0] div_m1,
  input  logic [HW-1:0] h_sync_m1,
  input  logic [HW-1:0] h_back_m1,
  input  logic [HW-1:0] h_act_m1,
  input  logic [HW-1:0] h_front_m1,
  input  logic [VW-1:0] v_sync_m1,
  input  logic [VW-1:0] v_back_m1,
  input  logic [VW-1:0] v_act_m1,
  input  logic [VW-1:0] v_front_m1,
  input  logic [VW-1:0] line_thresh,
  input  logic          irq_glob_en,
  input  logic          irq_frame_en,
  input  logic [1:0]    irq_sel,
  input  logic          irq_clr,
  output logic          pix_ce,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic [HW-1:0] h_cnt,
  output logic [VW-1:0] v_cnt,
  output logic          line_match,
  output logic          irq_pend,
  output logic          irq
);
  import rtg_pkg::*;

  // Named internal events, visible to the assertions.
  logic          h_wrap, v_wrap, line_step;
  logic          h_act, v_act;
  logic [HW-1:0] h_nxt;
  logic [VW-1:0] v_nxt;
  bounds_t       h_bnd, v_bnd;
  logic          frame_evt;

  rtg_pixdiv #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .run(video_en), .div_m1(div_m1), .tick(pix_ce)
  );

  rtg_axis #(.W(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .run(video_en), .step(pix_ce),
    .sync_m1(h_sync_m1), .back_m1(h_back_m1), .act_m1(h_act_m1), .front_m1(h_front_m1),
    .cnt(h_cnt), .cnt_nxt(h_nxt), .wrap(h_wrap), .in_sync(hsync), .in_act(h_act), .bnd(h_bnd)
  );

  assign line_step = pix_ce && h_wrap;

  rtg_axis #(.W(VW)) u_v (
    .clk(clk), .rst_n(rst_n), .run(video_en), .step(line_step),
    .sync_m1(v_sync_m1), .back_m1(v_back_m1), .act_m1(v_act_m1), .front_m1(v_front_m1),
    .cnt(v_cnt), .cnt_nxt(v_nxt), .wrap(v_wrap), .in_sync(vsync), .in_act(v_act), .bnd(v_bnd)
  );

  assign de         = h_act && v_act;
  assign line_match = video_en && (v_cnt == line_thresh);
  assign frame_evt  = line_step && (pos_t'(v_nxt) == sel_line(v_bnd, evt_sel_e'(irq_sel)));

  rtg_frame_irq u_irq (
    .clk(clk), .rst_n(rst_n), .evt(frame_evt), .src_en(irq_frame_en),
    .glob_en(irq_glob_en), .clr(irq_clr), .pend(irq_pend), .irq(irq)
  );

  // R5
  de_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!hsync && !vsync));

  // R4
  line_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (video_en && $past(video_en) && $past(line_step)) |-> (h_cnt == '0));

  // R6
  idle_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !video_en |-> !(pix_ce || hsync || vsync || de || line_match));

  // R8
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (irq_pend && irq_glob_en));

endmodule

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic [7:0] dv, hs, hb, ha, hf, vs, vb, va, vf, thr;
    logic [1:0] sel;
    logic       fen, gen;
  } cfg_t;

  // Stimulus vectors: divider, horizontal fields, vertical fields, threshold, source, enables.
  localparam cfg_t TBL [4] = '{
    '{8'd1, 8'd1, 8'd1, 8'd3, 8'd1, 8'd0, 8'd0, 8'd2, 8'd0, 8'd4, 2'd0, 1'b1, 1'b1},
    '{8'd0, 8'd1, 8'd2, 8'd4, 8'd1, 8'd1, 8'd0, 8'd1, 8'd1, 8'd3, 2'd2, 1'b1, 1'b0},
    '{8'd2, 8'd2, 8'd0, 8'd1, 8'd0, 8'd0, 8'd1, 8'd0, 8'd2, 8'd6, 2'd3, 1'b0, 1'b1},
    '{8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 8'd1, 8'd1, 8'd1, 8'd2, 2'd1, 1'b1, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic video_en = 1'b0;
  logic [7:0] div_m1 = '0;
  logic [11:0] h_sync_m1 = '0, h_back_m1 = '0, h_act_m1 = '0, h_front_m1 = '0;
  logic [10:0] v_sync_m1 = '0, v_back_m1 = '0, v_act_m1 = '0, v_front_m1 = '0, line_thresh = '0;
  logic irq_glob_en = 1'b0, irq_frame_en = 1'b0, irq_clr = 1'b0;
  logic [1:0] irq_sel = '0;
  logic pix_ce, hsync, vsync, de, line_match, irq_pend, irq;
  logic [11:0] h_cnt;
  logic [10:0] v_cnt;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst_n(rst_n), .video_en(video_en), .div_m1(div_m1),
    .h_sync_m1(h_sync_m1), .h_back_m1(h_back_m1), .h_act_m1(h_act_m1), .h_front_m1(h_front_m1),
    .v_sync_m1(v_sync_m1), .v_back_m1(v_back_m1), .v_act_m1(v_act_m1), .v_front_m1(v_front_m1),
    .line_thresh(line_thresh), .irq_glob_en(irq_glob_en), .irq_frame_en(irq_frame_en),
    .irq_sel(irq_sel), .irq_clr(irq_clr), .pix_ce(pix_ce), .hsync(hsync), .vsync(vsync),
    .de(de), .h_cnt(h_cnt), .v_cnt(v_cnt), .line_match(line_match),
    .irq_pend(irq_pend), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic load(input cfg_t c);
    div_m1 = c.dv;
    h_sync_m1 = 12'(c.hs); h_back_m1 = 12'(c.hb); h_act_m1 = 12'(c.ha); h_front_m1 = 12'(c.hf);
    v_sync_m1 = 11'(c.vs); v_back_m1 = 11'(c.vb); v_act_m1 = 11'(c.va); v_front_m1 = 11'(c.vf);
    line_thresh = 11'(c.thr); irq_sel = c.sel; irq_frame_en = c.fen; irq_glob_en = c.gen;
  endtask

  // Idle, load, clear the flag, then run n cycles comparing against a position model.
  task automatic run_cfg(input cfg_t c, input int n, input int clr_a, input int clr_b);
    int r, ht, vt, sl, p, h, v, ha0, ha1, va0, va1;
    bit pend_exp, evt;
    @(negedge clk);
    video_en = 1'b0;
    load(c);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    #1;
    // R9: clear while idle leaves the flag low
    check(irq_pend == 1'b0, "R9 clear", int'(irq_pend), 0);
    // R6: idle raster
    check({pix_ce, hsync, vsync, de, line_match} == 5'b0 && h_cnt == 0 && v_cnt == 0,
          "R6 idle", int'({pix_ce, hsync, vsync, de, line_match}), 0);
    @(negedge clk);
    r  = int'(c.dv) + 1;
    ht = int'(c.hs) + int'(c.hb) + int'(c.ha) + int'(c.hf) + 4;
    vt = int'(c.vs) + int'(c.vb) + int'(c.va) + int'(c.vf) + 4;
    ha0 = int'(c.hs) + int'(c.hb) + 2; ha1 = ha0 + int'(c.ha) + 1;
    va0 = int'(c.vs) + int'(c.vb) + 2; va1 = va0 + int'(c.va) + 1;
    case (c.sel)
      2'd1: sl = int'(c.vs) + 1;
      2'd2: sl = va0;
      2'd3: sl = va1;
      default: sl = 0;
    endcase
    pend_exp = 1'b0;
    video_en = 1'b1;
    for (int k = 0; k < n; k++) begin
      #1;
      p = k / r;
      h = p % ht;
      v = (p / ht) % vt;
      evt = (k > 0) && (k % r == 0) && (h == 0) && (v == sl) && c.fen;
      if (evt) pend_exp = 1'b1;
      else if (k > 0 && ((k - 1) == clr_a || (k - 1) == clr_b)) pend_exp = 1'b0;
      check(pix_ce == ((k % r) == r - 1), "R1 pix_ce", int'(pix_ce), int'((k % r) == r - 1));
      check(int'(h_cnt) == h, "R2 h_cnt", int'(h_cnt), h);
      check(hsync == (h <= int'(c.hs)), "R3 hsync", int'(hsync), int'(h <= int'(c.hs)));
      check(int'(v_cnt) == v && vsync == (v <= int'(c.vs)), "R4 v_cnt/vsync",
            int'(v_cnt), v);
      check(de == (h >= ha0 && h < ha1 && v >= va0 && v < va1), "R5 de", int'(de),
            int'(h >= ha0 && h < ha1 && v >= va0 && v < va1));
      check(line_match == (v == int'(c.thr)), "R10 line_match", int'(line_match),
            int'(v == int'(c.thr)));
      check(irq_pend == pend_exp, "R7 R9 irq_pend", int'(irq_pend), int'(pend_exp));
      check(irq == (pend_exp && c.gen), "R8 irq", int'(irq), int'(pend_exp && c.gen));
      irq_clr = (k == clr_a || k == clr_b);
      @(negedge clk);
    end
    irq_clr = 1'b0;
    video_en = 1'b0;
    #1;
    // R6: dropping video_en mid-frame forces outputs low at once
    check({pix_ce, hsync, vsync, de, line_match} == 5'b0, "R6 drop",
          int'({pix_ce, hsync, vsync, de, line_match}), 0);
    @(negedge clk);
    #1;
    check(h_cnt == 0 && v_cnt == 0, "R6 counters", int'(h_cnt) + int'(v_cnt), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    cfg_t c;
    int fr;
    // R11: reset state
    repeat (3) @(negedge clk);
    #1;
    check(h_cnt == 0 && v_cnt == 0 && !irq_pend && !irq, "R11 in reset",
          int'(h_cnt) + int'(v_cnt) + int'(irq_pend), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(h_cnt == 0 && v_cnt == 0 && !irq_pend && !irq, "R11 after release",
          int'(h_cnt) + int'(v_cnt) + int'(irq_pend), 0);

    // Table walk: each vector runs one frame plus two lines.
    for (int i = 0; i < 4; i++) begin
      c = TBL[i];
      fr = (int'(c.dv) + 1) * (int'(c.hs) + int'(c.hb) + int'(c.ha) + int'(c.hf) + 4);
      run_cfg(c, fr * (int'(c.vs) + int'(c.vb) + int'(c.va) + int'(c.vf) + 4) + 2 * fr, -1, -1);
    end

    // R9: clear in the same cycle as the vertical-wrap set (cycle 119 -> set at 120), then a lone clear.
    run_cfg(TBL[0], 160, 119, 140);

    // R7: frame source disabled, events never latch.
    c = TBL[0];
    c.fen = 1'b0;
    run_cfg(c, 140, -1, -1);

    // R1: largest divider field, ratio 256.
    c = TBL[0];
    c.dv = 8'hFF;
    run_cfg(c, 1100, -1, -1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule